// File: doc/BRIEF.md
# Delayed Debug Interrupt Controller

This block sits between the debug event detectors of a simple in-order core and its interrupt logic. Every cycle it receives hit pulses from two instruction address comparators and four data address comparators, together with a completion strobe that carries the address of the retiring instruction and the address that follows it. Hits are recorded in a sticky status register, which software reads and clears one bit at a time by writing ones. The block also holds the global debug-enable bit. Software sets that bit with the retiring-instruction pulse `en_set_i` and clears it with `en_clr_i`.

If a hit retires while debug is enabled, the block raises a precise debug interrupt and saves the address of the instruction that caused it. If the hit retires while debug is disabled, the status bit is recorded and nothing else happens. Later, when an instruction turns debug on while any event bit is still set, the block raises a delayed, imprecise interrupt. In that case the saved address points past the enabling instruction, and an imprecise flag in the status register tells the handler how to read it. The request lasts one cycle, and taking it turns debug off.

The control is a three-state machine:
- `ST_OFF`: debug is disabled.
- `ST_ON`: debug is enabled.
- `ST_TAKE`: the one-cycle interrupt request.

Its transitions are:
- `OFF->ON`: enable with nothing pending.
- `OFF->TAKE`: enable with something pending, which is the delayed case.
- `ON->TAKE`: a hit retires while enabled, which is the precise case.
- `ON->OFF`: software disable.
- `TAKE->OFF`: always, after the request cycle.

Top module: `dbg_intr_ctrl`

## Requirements
- R1: After reset the status register reads 0, `dbg_en_o` is 0, `dbg_irq_o` is 0 and `save_pc_o` is 0.
- R2: Status bit layout: bits 1:0 are instruction-compare hits 1:0, bits 5:2 are data-compare hits 3:0 and bit 6 is the imprecise flag. A hit is recorded on the edge where it is present together with `cmpl_valid_i`, and it is visible in the cycle after that edge. A hit without `cmpl_valid_i` is ignored.
- R3: Writing the status register with `sts_we_i` clears every bit whose `sts_wdata_i` bit is 1 and leaves the others unchanged. Without a write, no status bit ever drops.
- R4: A hit that retires in the same cycle as a write clearing its bit leaves that bit set.
- R5: While `dbg_en_o` is 1, a retiring hit raises `dbg_irq_o` in the next cycle, with `save_pc_o` equal to that instruction's `cmpl_pc_i`. The imprecise flag is not set.
- R6: While `dbg_en_o` is 0, a retiring hit never raises `dbg_irq_o` unless an enable takes effect.
- R7: While debug is disabled, a retiring `en_set_i` raises `dbg_irq_o` in the next cycle when any event bit (bits 5:0) is set after that cycle's updates. `save_pc_o` then equals `cmpl_next_pc_i`, and the imprecise flag becomes set.
- R8: A retiring `en_set_i` with no event bit pending sets `dbg_en_o` in the next cycle and raises no interrupt.
- R9: `dbg_irq_o` is high for exactly one cycle, and `dbg_en_o` is 0 from the request onwards. Pending status bits do not raise another request until debug is enabled again.
- R10: A retiring `en_clr_i` makes `dbg_en_o` 0 in the next cycle. If a hit retires in the same cycle while debug is enabled, the precise interrupt is still raised.
- R11: During the request cycle, `en_set_i` has no effect, so `dbg_en_o` is 0 afterwards. Hits retiring in that cycle are still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmpl_valid_i | input | 1 | An instruction retires this cycle |
| cmpl_pc_i | input | ADDR_W | Address of the retiring instruction |
| cmpl_next_pc_i | input | ADDR_W | Address of the instruction after it |
| iac_hit_i | input | N_IAC | Instruction-compare hit pulses |
| dac_hit_i | input | N_DAC | Data-compare hit pulses |
| en_set_i | input | 1 | Retiring instruction turns debug on |
| en_clr_i | input | 1 | Retiring instruction turns debug off |
| sts_we_i | input | 1 | Status write-one-to-clear strobe |
| sts_wdata_i | input | N_IAC+N_DAC+1 | Clear mask |
| sts_rdata_o | output | N_IAC+N_DAC+1 | Status register |
| dbg_en_o | output | 1 | Global debug-enable bit |
| dbg_irq_o | output | 1 | One-cycle debug interrupt request |
| save_pc_o | output | ADDR_W | Save/restore address for the request |

## Verification
A wrong state in the machine shows up within one cycle on `dbg_en_o` or `dbg_irq_o`. Examples are an enable that survives a taken request, or a request that repeats. A wrong status bit shows up at once on `sts_rdata_o`. It surfaces again at the next enable, as a missing or spurious delayed request. A wrong save-address selection appears in the request cycle, when `save_pc_o` shows the causing address or the following address. The sweep runs every combination of the six hit lines through both the precise path and the delayed path, and every clear mask.

// File: rtl/dbg_intr_pkg.sv
package dbg_intr_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ON   = 2'd1,
        ST_TAKE = 2'd2
    } dbg_state_e;

endpackage

// File: rtl/dbg_status_reg.sv
module dbg_status_reg #(
    parameter int N_EVT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_set_i,
    input  logic             imp_set_i,
    input  logic             wr_en_i,
    input  logic [N_EVT:0]   wr_mask_i,
    output logic [N_EVT:0]   sts_q_o,
    output logic             evt_pend_next_o
);
    localparam int W = N_EVT + 1;

    logic [W-1:0] set_vec;
    logic [W-1:0] clr_vec;
    logic [W-1:0] sts_d;
    logic [W-1:0] sts_q;

    assign set_vec = {imp_set_i, evt_set_i};
    assign clr_vec = wr_en_i ? wr_mask_i : '0;

    // per-bit sticky cell: a set beats a clear in the same cycle
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sts_d[i] = set_vec[i] | (sts_q[i] & ~clr_vec[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    assign sts_q_o         = sts_q;
    assign evt_pend_next_o = |sts_d[N_EVT-1:0];
endmodule

// File: rtl/dbg_ctrl_fsm.sv
module dbg_ctrl_fsm
    import dbg_intr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmpl_valid_i,
    input  logic hit_any_i,
    input  logic en_set_i,
    input  logic en_clr_i,
    input  logic pend_next_i,
    output logic take_precise_o,
    output logic take_delayed_o,
    output logic dbg_en_o,
    output logic dbg_irq_o
);
    dbg_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d        = state_q;
        take_precise_o = 1'b0;
        take_delayed_o = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (cmpl_valid_i && en_set_i) begin
                    if (pend_next_i) begin
                        state_d        = ST_TAKE;
                        take_delayed_o = 1'b1;
                    end else begin
                        state_d = ST_ON;
                    end
                end
            end
            ST_ON: begin
                if (cmpl_valid_i && hit_any_i) begin
                    state_d        = ST_TAKE;
                    take_precise_o = 1'b1;
                end else if (cmpl_valid_i && en_clr_i) begin
                    state_d = ST_OFF;
                end
            end
            ST_TAKE: state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        dbg_en_o  = (state_q == ST_ON);
        dbg_irq_o = (state_q == ST_TAKE);
    end
endmodule

// File: rtl/dbg_save_addr.sv
module dbg_save_addr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_precise_i,
    input  logic              take_delayed_i,
    input  logic [ADDR_W-1:0] cmpl_pc_i,
    input  logic [ADDR_W-1:0] cmpl_next_pc_i,
    output logic [ADDR_W-1:0] save_pc_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              save_pc_o <= '0;
        else if (take_precise_i) save_pc_o <= cmpl_pc_i;
        else if (take_delayed_i) save_pc_o <= cmpl_next_pc_i;
    end
endmodule

// File: rtl/dbg_intr_ctrl.sv
module dbg_intr_ctrl #(
    parameter int ADDR_W = 32,
    parameter int N_IAC  = 2,
    parameter int N_DAC  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmpl_valid_i,
    input  logic [ADDR_W-1:0]        cmpl_pc_i,
    input  logic [ADDR_W-1:0]        cmpl_next_pc_i,
    input  logic [N_IAC-1:0]         iac_hit_i,
    input  logic [N_DAC-1:0]         dac_hit_i,
    input  logic                     en_set_i,
    input  logic                     en_clr_i,
    input  logic                     sts_we_i,
    input  logic [N_IAC+N_DAC:0]     sts_wdata_i,
    output logic [N_IAC+N_DAC:0]     sts_rdata_o,
    output logic                     dbg_en_o,
    output logic                     dbg_irq_o,
    output logic [ADDR_W-1:0]        save_pc_o
);
    localparam int N_EVT = N_IAC + N_DAC;

    logic [N_EVT-1:0] hit_q;
    logic             hit_any;
    logic             pend_next;
    logic             take_p;
    logic             take_d;

    assign hit_q   = cmpl_valid_i ? {dac_hit_i, iac_hit_i} : '0;
    assign hit_any = |hit_q;

    dbg_status_reg #(.N_EVT(N_EVT)) u_sts (
        .clk             (clk),
        .rst_n           (rst_n),
        .evt_set_i       (hit_q),
        .imp_set_i       (take_d),
        .wr_en_i         (sts_we_i),
        .wr_mask_i       (sts_wdata_i),
        .sts_q_o         (sts_rdata_o),
        .evt_pend_next_o (pend_next)
    );

    dbg_ctrl_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmpl_valid_i   (cmpl_valid_i),
        .hit_any_i      (hit_any),
        .en_set_i       (en_set_i),
        .en_clr_i       (en_clr_i),
        .pend_next_i    (pend_next),
        .take_precise_o (take_p),
        .take_delayed_o (take_d),
        .dbg_en_o       (dbg_en_o),
        .dbg_irq_o      (dbg_irq_o)
    );

    dbg_save_addr #(.ADDR_W(ADDR_W)) u_save (
        .clk            (clk),
        .rst_n          (rst_n),
        .take_precise_i (take_p),
        .take_delayed_i (take_d),
        .cmpl_pc_i      (cmpl_pc_i),
        .cmpl_next_pc_i (cmpl_next_pc_i),
        .save_pc_o      (save_pc_o)
    );
endmodule

// File: rtl/dbg_intr_ctrl_chk.sv
module dbg_intr_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int N_IAC  = 2,
    parameter int N_DAC  = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmpl_valid_i,
    input logic [ADDR_W-1:0]    cmpl_pc_i,
    input logic [ADDR_W-1:0]    cmpl_next_pc_i,
    input logic [N_IAC-1:0]     iac_hit_i,
    input logic [N_DAC-1:0]     dac_hit_i,
    input logic                 en_set_i,
    input logic                 en_clr_i,
    input logic                 sts_we_i,
    input logic [N_IAC+N_DAC:0] sts_wdata_i,
    input logic [N_IAC+N_DAC:0] sts_rdata_o,
    input logic                 dbg_en_o,
    input logic                 dbg_irq_o,
    input logic [ADDR_W-1:0]    save_pc_o
);
    localparam int N_EVT = N_IAC + N_DAC;

    logic [N_EVT-1:0] hits;
    assign hits = cmpl_valid_i ? {dac_hit_i, iac_hit_i} : '0;

    assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_irq_o |=> !dbg_irq_o);

    assert_irq_drops_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_irq_o |-> !dbg_en_o);

    assert_precise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_en_o && |hits) |=> (dbg_irq_o && save_pc_o == $past(cmpl_pc_i)));

    assert_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_en_o && !(cmpl_valid_i && en_set_i)) |=> !dbg_irq_o);

    assert_delayed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_en_o && !dbg_irq_o && cmpl_valid_i && en_set_i && |hits)
        |=> (dbg_irq_o && save_pc_o == $past(cmpl_next_pc_i) && sts_rdata_o[N_EVT]));

    assert_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_en_o && !dbg_irq_o && cmpl_valid_i && en_set_i
         && sts_rdata_o[N_EVT-1:0] == '0 && hits == '0)
        |=> (dbg_en_o && !dbg_irq_o));

    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_we_i |=> ((sts_rdata_o & $past(sts_rdata_o)) == $past(sts_rdata_o)));

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid_i |=> ((sts_rdata_o[N_EVT-1:0] & $past(hits)) == $past(hits)));
endmodule

bind dbg_intr_ctrl dbg_intr_ctrl_chk #(
    .ADDR_W(ADDR_W), .N_IAC(N_IAC), .N_DAC(N_DAC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmpl_valid_i(cmpl_valid_i),
    .cmpl_pc_i(cmpl_pc_i), .cmpl_next_pc_i(cmpl_next_pc_i),
    .iac_hit_i(iac_hit_i), .dac_hit_i(dac_hit_i),
    .en_set_i(en_set_i), .en_clr_i(en_clr_i),
    .sts_we_i(sts_we_i), .sts_wdata_i(sts_wdata_i),
    .sts_rdata_o(sts_rdata_o), .dbg_en_o(dbg_en_o),
    .dbg_irq_o(dbg_irq_o), .save_pc_o(save_pc_o)
);

// File: tb/sim_dbg_intr_ctrl.sv
module sim_dbg_intr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmpl_valid = 1'b0;
    logic [31:0] cmpl_pc = '0;
    logic [31:0] cmpl_next_pc = '0;
    logic [1:0]  iac_hit = '0;
    logic [3:0]  dac_hit = '0;
    logic        en_set = 1'b0;
    logic        en_clr = 1'b0;
    logic        sts_we = 1'b0;
    logic [6:0]  sts_wdata = '0;
    logic [6:0]  sts;
    logic        dbg_en;
    logic        dbg_irq;
    logic [31:0] save_pc;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dbg_intr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmpl_valid_i(cmpl_valid),
        .cmpl_pc_i(cmpl_pc), .cmpl_next_pc_i(cmpl_next_pc),
        .iac_hit_i(iac_hit), .dac_hit_i(dac_hit),
        .en_set_i(en_set), .en_clr_i(en_clr),
        .sts_we_i(sts_we), .sts_wdata_i(sts_wdata),
        .sts_rdata_o(sts), .dbg_en_o(dbg_en),
        .dbg_irq_o(dbg_irq), .save_pc_o(save_pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cmpl_valid = 0; cmpl_pc = '0; cmpl_next_pc = '0;
        iac_hit = '0; dac_hit = '0; en_set = 0; en_clr = 0;
        sts_we = 0; sts_wdata = '0;
    endtask

    // drive one cycle, then return at the next falling edge with inputs idle
    task automatic cyc();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic retire(input logic [5:0] p, input logic [31:0] pc, input logic [31:0] npc,
                          input logic s, input logic c);
        cmpl_valid = 1; cmpl_pc = pc; cmpl_next_pc = npc;
        iac_hit = p[1:0]; dac_hit = p[5:2]; en_set = s; en_clr = c;
    endtask

    task automatic clear_all();
        sts_we = 1; sts_wdata = 7'h7F; cyc();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 sts", {25'd0, sts}, 32'd0);
        chk("R1 en", {31'd0, dbg_en}, 32'd0);
        chk("R1 irq", {31'd0, dbg_irq}, 32'd0);
        chk("R1 save", save_pc, 32'd0);

        // sweep every hit combination through delayed and precise paths
        for (int p = 1; p < 64; p++) begin
            logic [31:0] pc_a, pc_b, pc_c;
            pc_a = 32'h1000_0000 + p * 4;
            pc_b = 32'h2000_0000 + p * 8;
            pc_c = 32'h3000_0000 + p * 12;
            retire(p[5:0], pc_a, pc_a + 4, 0, 0); cyc();
            chk("R6 no irq while disabled", {31'd0, dbg_irq}, 32'd0);
            chk("R2 recorded", {25'd0, sts}, p);
            retire(6'd0, pc_b, pc_b + 4, 1, 0); cyc();
            chk("R7 delayed irq", {31'd0, dbg_irq}, 32'd1);
            chk("R7 save next pc", save_pc, pc_b + 4);
            chk("R7 imprecise flag", {25'd0, sts}, p | 64);
            chk("R9 en off on take", {31'd0, dbg_en}, 32'd0);
            cyc();
            chk("R9 single pulse", {31'd0, dbg_irq}, 32'd0);
            cyc();
            chk("R9 no retrigger", {31'd0, dbg_irq}, 32'd0);
            clear_all();
            chk("R3 cleared", {25'd0, sts}, 32'd0);
            retire(6'd0, pc_b, pc_b + 4, 1, 0); cyc();
            chk("R8 enabled", {31'd0, dbg_en}, 32'd1);
            chk("R8 no irq", {31'd0, dbg_irq}, 32'd0);
            retire(p[5:0], pc_c, pc_c + 4, 0, 0); cyc();
            chk("R5 precise irq", {31'd0, dbg_irq}, 32'd1);
            chk("R5 save pc", save_pc, pc_c);
            chk("R5 imprecise clear", {25'd0, sts}, p);
            cyc();
            chk("R9 en stays off", {31'd0, dbg_en}, 32'd0);
            clear_all();
        end

        // hits without a retiring instruction are ignored
        for (int p = 1; p < 64; p++) begin
            iac_hit = p[1:0]; dac_hit = p[5:2]; cyc();
            chk("R2 ignored without valid", {25'd0, sts}, 32'd0);
        end

        // every clear mask against a full status register
        for (int m = 0; m < 128; m++) begin
            retire(6'h3F, 32'h40, 32'h44, 0, 0); cyc();
            retire(6'd0, 32'h44, 32'h48, 1, 0); cyc();   // delayed take sets bit 6
            cyc();
            sts_we = 1; sts_wdata = m[6:0]; cyc();
            chk("R3 partial clear", {25'd0, sts}, 7'h7F & ~m[6:0]);
            clear_all();
        end

        // hit and clear in the same cycle
        for (int p = 1; p < 64; p++) begin
            retire(p[5:0], 32'h80, 32'h84, 0, 0);
            sts_we = 1; sts_wdata = 7'h7F; cyc();
            chk("R4 set beats clear", {25'd0, sts}, p);
            clear_all();
        end

        // enable and a hit retiring together from the disabled state
        retire(6'h04, 32'h500, 32'h504, 1, 0); cyc();
        chk("R7 same-cycle hit irq", {31'd0, dbg_irq}, 32'd1);
        chk("R7 same-cycle save", save_pc, 32'h504);
        cyc(); clear_all();

        // software disable
        retire(6'd0, 32'h600, 32'h604, 1, 0); cyc();
        retire(6'd0, 32'h604, 32'h608, 0, 1); cyc();
        chk("R10 disabled", {31'd0, dbg_en}, 32'd0);
        chk("R10 no irq", {31'd0, dbg_irq}, 32'd0);
        retire(6'd0, 32'h608, 32'h60C, 1, 0); cyc();
        retire(6'h01, 32'h60C, 32'h610, 0, 1); cyc();
        chk("R10 hit beats disable", {31'd0, dbg_irq}, 32'd1);
        chk("R10 save pc", save_pc, 32'h60C);
        // enable attempt and a hit during the request cycle
        retire(6'h20, 32'h610, 32'h614, 1, 0); cyc();
        chk("R11 enable ignored", {31'd0, dbg_en}, 32'd0);
        chk("R11 no second irq", {31'd0, dbg_irq}, 32'd0);
        chk("R11 hit recorded", {25'd0, sts}, 32'h21);
        chk("R11 save held", save_pc, 32'h60C);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule